// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous serial line into characters. The block clock is the receive clock. It runs at 1, 16 or 64 times the bit rate, as the rate field selects. A falling edge on the idle-high line starts a character. In the oversampled modes the start bit is checked again at its midpoint, and a start that has already gone high is dropped. The block then samples each data bit, an optional parity bit and one stop bit at the centre of the bit. The character goes into a holding register and is offered to the host on a valid/ready output.

The host takes a character by raising `rx_ready` while `rx_valid` is high. Back-pressure works as follows. While `rx_valid` is high and `rx_ready` is low, the character is held steady. If the next character completes before the host has taken the current one, the new character replaces it and the overrun flag is set. Parity, overrun and framing errors are sticky until `err_clr` is pulsed.

A line held low for a whole character raises `brk_det`. This covers the start, data, parity and stop positions, all sampled low. `brk_det` drops as soon as the line is high again. A loopback select takes the receiver input from a local transmitter output instead of the line pin.

Top module: `rxr_async_rx`

## Requirements
- R1: Frame format. The frame is one low start bit, then 5, 6, 7 or 8 data bits (`cfg_len` = 0, 1, 2, 3), least significant bit first, then an optional parity bit, then one stop bit. `rx_data` holds the data right-aligned, with the unused upper bits at zero.
- R2: Oversampling rate. `cfg_rate` = 0 selects x1, 1 selects x16, and 2 or 3 selects x64. In x16 mode the start is confirmed 8 cycles after the edge is seen, and every later bit is sampled 16 cycles after the one before. In x64 mode these counts are 32 and 64. In x1 mode every cycle is one bit.
- R3: False start. In x16 and x64 modes, a start bit that is no longer low at its midpoint produces no character and no error flag, and hunting for a start resumes.
- R4: Parity. With `cfg_par_en` = 1, the parity bit follows the data. `cfg_par_odd` = 0 means an even number of ones across data and parity; 1 means an odd number. A mismatch sets `err_parity`. With parity disabled, `err_parity` is never set.
- R5: Framing. A stop bit sampled low sets `err_framing`. After such a frame, the receiver does not hunt for a new start until the line has been high.
- R6: Output handshake. `rx_valid` rises when a character is stored. While `rx_ready` is low, `rx_valid` stays high and `rx_data` stays stable. `rx_valid` falls one cycle after a cycle with `rx_valid` and `rx_ready` both high, unless a new character is stored in that same cycle.
- R7: Overrun. A character stored while `rx_valid` is high and `rx_ready` is low sets `err_overrun` and replaces the held data. A character stored in the same cycle as a read does not set `err_overrun`.
- R8: Error flags remain set, including across host reads, until `err_clr` is high for one cycle.
- R9: Break. `brk_det` rises when a character completes with its start, data, parity (if enabled) and stop positions all sampled low. It clears once the line is high again. A zero character with a high stop bit does not raise it.
- R10: Loopback. With `loop_en` = 1, the receiver takes its serial input from `loop_txd`, and `rxd` has no effect.
- R11: After reset, `rx_valid`, all error flags and `brk_det` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock (1, 16 or 64 times the bit rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line input, idle high |
| loop_en | input | 1 | Selects loop_txd as receiver input |
| loop_txd | input | 1 | Local transmitter serial output for loopback |
| cfg_len | input | 2 | Data length: 0=5, 1=6, 2=7, 3=8 bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_rate | input | 2 | 0 = x1, 1 = x16, 2/3 = x64 |
| rx_valid | output | 1 | Holding register holds an unread character |
| rx_ready | input | 1 | Host takes the character this cycle |
| rx_data | output | 8 | Received character, right-aligned |
| err_clr | input | 1 | Clears all sticky error flags |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_framing | output | 1 | Sticky framing error |
| brk_det | output | 1 | Break condition on the line |

## Verification
A character can be stored in the same cycle the host reads the previous one. In that cycle the output must stay valid, show the new character and report no overrun. The bench first measures how many cycles pass from the start of the stop bit to `rx_valid` rising. It then places `rx_ready` exactly in the storing cycle, one cycle earlier, and not at all. It checks the valid, data and overrun results of each case against the rules in R6 and R7.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          perr;
    logic          ferr;
  } rx_char_t;

endpackage

// File: rtl/rxr_line_front.sv
module rxr_line_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic loop_en,
  input  logic loop_txd,
  output logic line
);

  logic [SYNC-1:0] sync_q;
  logic            src;

  assign src = loop_en ? loop_txd : rxd;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= src;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC-2:0], src};
      end
    end
  endgenerate

  assign line = sync_q[SYNC-1];

endmodule

// File: rtl/rxr_deframer.sv
module rxr_deframer
  import rxr_pkg::*;
#(
  parameter int OS_MID = 16,
  parameter int OS_HI  = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line,
  input  logic [1:0] cfg_len,
  input  logic     cfg_par_en,
  input  logic     cfg_par_odd,
  input  logic [1:0] cfg_rate,
  output logic     push,
  output rx_char_t pchar,
  output logic     brk
);

  localparam int CNT_W = $clog2(OS_HI + 1);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] half;
  logic [2:0]       bitidx;
  logic [2:0]       last_idx;
  logic [DW-1:0]    sh;
  logic [DW-1:0]    aligned;
  logic             pbit;
  logic             at_mark;

  always_comb begin
    case (cfg_rate)
      2'd0: begin
        period = CNT_W'(1);
        half   = '0;
      end
      2'd1: begin
        period = CNT_W'(OS_MID);
        half   = CNT_W'(OS_MID / 2);
      end
      default: begin
        period = CNT_W'(OS_HI);
        half   = CNT_W'(OS_HI / 2);
      end
    endcase
  end

  assign last_idx = {1'b0, cfg_len} + 3'd4;
  assign aligned  = sh >> (2'd3 - cfg_len);
  assign at_mark  = (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_HUNT;
      cnt    <= CNT_W'(1);
      bitidx <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      push   <= 1'b0;
      pchar  <= '0;
      brk    <= 1'b0;
    end else begin
      push <= 1'b0;
      if (line) brk <= 1'b0;
      case (st)
        ST_HUNT: begin
          if (!line) begin
            cnt    <= CNT_W'(1);
            bitidx <= '0;
            pbit   <= 1'b0;
            st     <= (half == '0) ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (cnt == half) begin
            cnt <= CNT_W'(1);
            st  <= line ? ST_HUNT : ST_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (at_mark) begin
            cnt    <= CNT_W'(1);
            sh     <= {line, sh[DW-1:1]};
            bitidx <= bitidx + 3'd1;
            if (bitidx == last_idx) st <= cfg_par_en ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (at_mark) begin
            cnt  <= CNT_W'(1);
            pbit <= line;
            st   <= ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (at_mark) begin
            cnt        <= CNT_W'(1);
            push       <= 1'b1;
            pchar.data <= aligned;
            pchar.perr <= cfg_par_en & (^aligned ^ pbit ^ cfg_par_odd);
            pchar.ferr <= ~line;
            if (!line && aligned == '0 && !(cfg_par_en && pbit)) brk <= 1'b1;
            st <= line ? ST_HUNT : ST_WAITHI;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WAITHI: begin
          if (line) st <= ST_HUNT;
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  AST_PUSH_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ($past(st) == ST_STOP)) else $error("push outside stop"); // R1

endmodule

// File: rtl/rxr_holding.sv
module rxr_holding
  import rxr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_char_t      pchar,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          err_clr,
  output logic          err_parity,
  output logic          err_overrun,
  output logic          err_framing
);

  logic take;
  logic ovr_set;

  assign take    = out_valid & out_ready;
  assign ovr_set = push & out_valid & ~out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      err_framing <= 1'b0;
    end else begin
      if (push) begin
        out_valid <= 1'b1;
        out_data  <= pchar.data;
      end else if (take) begin
        out_valid <= 1'b0;
      end
      err_parity  <= (push & pchar.perr) | (err_parity  & ~err_clr);
      err_framing <= (push & pchar.ferr) | (err_framing & ~err_clr);
      err_overrun <= ovr_set             | (err_overrun & ~err_clr);
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid) else $error("valid dropped"); // R6
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !push |=> $stable(out_data)) else $error("data moved"); // R6
  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    push && out_valid && !out_ready |=> err_overrun) else $error("overrun missed"); // R7

endmodule

// File: rtl/rxr_async_rx.sv
module rxr_async_rx
  import rxr_pkg::*;
#(
  parameter int SYNC   = 2,
  parameter int OS_MID = 16,
  parameter int OS_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       loop_en,
  input  logic       loop_txd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_rate,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  input  logic       err_clr,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_framing,
  output logic       brk_det
);

  logic     line;
  logic     push;
  rx_char_t pchar;

  rxr_line_front #(.SYNC(SYNC)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxd      (rxd),
    .loop_en  (loop_en),
    .loop_txd (loop_txd),
    .line     (line)
  );

  rxr_deframer #(.OS_MID(OS_MID), .OS_HI(OS_HI)) u_deframer (
    .clk         (clk),
    .rst_n       (rst_n),
    .line        (line),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_rate    (cfg_rate),
    .push        (push),
    .pchar       (pchar),
    .brk         (brk_det)
  );

  rxr_holding u_holding (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pchar       (pchar),
    .out_valid   (rx_valid),
    .out_ready   (rx_ready),
    .out_data    (rx_data),
    .err_clr     (err_clr),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .err_framing (err_framing)
  );

  AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    line |=> !brk_det) else $error("break held on high line"); // R9

endmodule

// File: tb/rxr_async_rx_bench.sv
module rxr_async_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       loop_en = 1'b0;
  logic       loop_txd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       err_clr = 1'b0;
  logic       err_parity;
  logic       err_overrun;
  logic       err_framing;
  logic       brk_det;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  use_loop = 1'b0;
  int  per    = 1;
  int  dlat   = 0;

  always #5 clk = ~clk;

  rxr_async_rx u_rxr_async_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .loop_en(loop_en), .loop_txd(loop_txd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_rate(cfg_rate), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .err_clr(err_clr), .err_parity(err_parity), .err_overrun(err_overrun),
    .err_framing(err_framing), .brk_det(brk_det)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int len, input bit pe, input bit po, input int rate);
    cfg_len     = 2'(len - 5);
    cfg_par_en  = pe;
    cfg_par_odd = po;
    cfg_rate    = 2'(rate);
    per = (rate == 0) ? 1 : (rate == 1) ? 16 : 64;
  endtask

  task automatic drive_bit(input bit b, input int n);
    if (use_loop) loop_txd = b; else rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_body(input int d, input int len, input bit pe, input bit po, input bit bad);
    bit pb;
    drive_bit(1'b0, per);
    pb = po ^ bad;
    for (int i = 0; i < len; i++) begin
      drive_bit(d[i], per);
      pb = pb ^ d[i];
    end
    if (pe) drive_bit(pb, per);
  endtask

  task automatic send(input int d, input int len, input bit pe, input bit po, input bit bad);
    drive_body(d, len, pe, po, bad);
    drive_bit(1'b1, per);
    drive_bit(1'b1, per + 2);
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (rx_valid) begin
        got = 1'b1;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic read_one();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic clear_errs();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit got;
    int vals[3];
    int nv;
    int mask;
    bit bad;
    int exp_par;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid", int'(rx_valid), 0);
    chk("R11 errors", int'({err_parity, err_overrun, err_framing}), 0);
    chk("R11 break", int'(brk_det), 0);

    // R1 R2 R4 sweep over rate, length and parity mode
    for (int r = 0; r < 3; r++) begin
      for (int len = 5; len <= 8; len++) begin
        for (int pm = 0; pm < 3; pm++) begin
          if (r == 2 && (len != 8 || pm == 1)) continue;
          setup(len, pm != 0, pm == 2, r);
          mask = (1 << len) - 1;
          nv = (r == 0) ? (1 << len) : (r == 1) ? 3 : 1;
          vals[0] = 0; vals[1] = mask; vals[2] = 32'h5A & mask;
          if (r == 2) vals[0] = 32'hA3;
          for (int k = 0; k < nv; k++) begin
            int v;
            v = (r == 0) ? k : vals[k];
            bad = (pm != 0) && (v % 7 == 3);
            send(v, len, pm != 0, pm == 2, bad);
            wait_valid(got);
            chk("R6 valid after frame", int'(got), 1);
            if (r == 0) chk("R1 data", int'(rx_data), v);
            else        chk("R2 data at rate", int'(rx_data), v);
            exp_par = bad ? 1 : 0;
            chk("R4 parity flag", int'(err_parity), exp_par);
            chk("R5 no framing", int'(err_framing), 0);
            chk("R9 no break on good zero", int'(brk_det), 0);
            read_one();
            chk("R6 valid falls after read", int'(rx_valid), 0);
            if (bad) begin
              chk("R8 parity sticky after read", int'(err_parity), 1);
              clear_errs();
              chk("R8 parity cleared", int'(err_parity), 0);
            end
          end
        end
      end
    end

    // R3 false start at x16
    setup(8, 1'b0, 1'b0, 1);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk("R3 no char from glitch", int'(rx_valid), 0);
    chk("R3 no error from glitch", int'({err_parity, err_overrun, err_framing}), 0);
    send(8'hC5, 8, 1'b0, 1'b0, 1'b0);
    wait_valid(got);
    chk("R3 hunting resumed", int'(rx_data), 8'hC5);
    read_one();

    // R5 framing error and wait for high
    drive_body(8'h81, 8, 1'b0, 1'b0, 1'b0);
    drive_bit(1'b0, 48);
    drive_bit(1'b1, 40);
    wait_valid(got);
    chk("R5 data kept", int'(rx_data), 8'h81);
    chk("R5 framing flag", int'(err_framing), 1);
    chk("R9 no break on nonzero", int'(brk_det), 0);
    read_one();
    clear_errs();
    repeat (250) @(negedge clk);
    chk("R5 no rehunt on low line", int'(rx_valid), 0);
    chk("R8 framing cleared", int'(err_framing), 0);

    // R9 break
    rxd = 1'b0;
    repeat (10 * 16 + 4) @(negedge clk);
    chk("R9 break raised", int'(brk_det), 1);
    chk("R9 framing with break", int'(err_framing), 1);
    chk("R9 zero char", int'(rx_data), 0);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 break cleared", int'(brk_det), 0);
    read_one();
    clear_errs();
    repeat (40) @(negedge clk);

    // R6 R7 measure latency from stop start to valid
    drive_body(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    rxd = 1'b1;
    dlat = 0;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (rx_valid) begin dlat = k; break; end
    end
    chk("R6 latency found", int'(dlat > 2), 1);
    drive_bit(1'b1, 32);
    read_one();

    // R7 read in the storing cycle
    send(8'h11, 8, 1'b0, 1'b0, 1'b0);
    drive_body(8'h22, 8, 1'b0, 1'b0, 1'b0);
    rxd = 1'b1;
    for (int k = 1; k <= dlat; k++) begin
      @(negedge clk);
      rx_ready = (k == dlat - 1);
      if (k == dlat) begin
        chk("R6 valid on collision", int'(rx_valid), 1);
        chk("R7 new data on collision", int'(rx_data), 8'h22);
        chk("R7 no overrun on collision", int'(err_overrun), 0);
      end
    end
    drive_bit(1'b1, 32);
    read_one();
    chk("R6 empty after read", int'(rx_valid), 0);

    // R7 read one cycle early
    send(8'h55, 8, 1'b0, 1'b0, 1'b0);
    drive_body(8'h66, 8, 1'b0, 1'b0, 1'b0);
    rxd = 1'b1;
    for (int k = 1; k <= dlat; k++) begin
      @(negedge clk);
      rx_ready = (k == dlat - 2);
      if (k == dlat - 1) chk("R6 consumed before store", int'(rx_valid), 0);
      if (k == dlat) begin
        chk("R6 valid after early read", int'(rx_valid), 1);
        chk("R7 data after early read", int'(rx_data), 8'h66);
        chk("R7 no overrun after early read", int'(err_overrun), 0);
      end
    end
    drive_bit(1'b1, 32);
    read_one();

    // R7 genuine overrun
    send(8'h33, 8, 1'b0, 1'b0, 1'b0);
    send(8'h44, 8, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun flag", int'(err_overrun), 1);
    chk("R7 newer data kept", int'(rx_data), 8'h44);
    read_one();
    chk("R8 overrun sticky", int'(err_overrun), 1);
    clear_errs();
    chk("R8 overrun cleared", int'(err_overrun), 0);

    // R10 loopback, rxd held low
    loop_txd = 1'b1;
    loop_en  = 1'b1;
    rxd      = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 rxd ignored", int'(rx_valid), 0);
    use_loop = 1'b1;
    send(8'h9C, 8, 1'b0, 1'b0, 1'b0);
    use_loop = 1'b0;
    wait_valid(got);
    chk("R10 loop data", int'(rx_data), 8'h9C);
    chk("R10 loop no framing", int'(err_framing), 0);
    read_one();
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    loop_en = 1'b0;
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule